// File: doc/BRIEF.md
# Registered Output Macrocell Bank

This block is the output stage of a programmable sum-of-products device. Each of its cells receives one OR-plane result, applies a per-cell polarity choice and then either hands the value straight to its pad or first captures it in a D flip-flop clocked by the shared device clock. Every cell drives a pad as a data/enable pair. It also returns a true and a complemented feedback signal for the product-term array.

Two configuration bits per cell select its behaviour. The mode bit chooses registered or combinational operation. The invert bit chooses the polarity. A registered cell takes its pad enable from the shared enable pin, and its feedback comes from the flip-flop itself, so the feedback stays valid while the pad is disabled. A combinational cell takes its enable from a dedicated product term. Its feedback reads the pad, so the pad can also serve as an input.

Top module: `olmc_bank`

## Requirements
- R1: While `rst` is high at a rising clock edge, every cell's flip-flop is loaded with 0. Directly after that edge, a cell in registered mode drives `pad_out`=0, `fb_q`=0 and `fb_qn`=1.
- R2: A cell in registered mode (`cfg_reg`=1) drives `pad_out` with the value its flip-flop captured at the most recent rising edge. That value is the polarity-adjusted sum.
- R3: The polarity-adjusted sum is `sum_in` XOR `cfg_inv`. An invert bit of 1 flips the value on both the registered path and the combinational path.
- R4: In registered mode, `pad_oe` equals the shared input `oe_common`.
- R5: In combinational mode (`cfg_reg`=0), `pad_out` equals the polarity-adjusted sum in the same cycle and `pad_oe` equals that cell's `pt_oe` bit.
- R6: In registered mode, `fb_q` is the flip-flop output and `fb_qn` is its complement, whatever the state of `oe_common` is.
- R7: In combinational mode, `fb_q` equals that cell's `pad_in` bit and `fb_qn` is its complement.
- R8: Each flip-flop loads the polarity-adjusted sum on every edge, whatever its mode is. After a switch from combinational to registered mode, the pad shows the value captured at the last edge.
- R9: Each cell follows only its own configuration, sum, enable and pad bits, so cells with mixed settings do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared device clock |
| rst | input | 1 | Synchronous active-high reset, clears all flip-flops |
| oe_common | input | 1 | Shared pad enable used by registered cells |
| sum_in | input | NUM_CELLS | OR-plane result for each cell |
| pt_oe | input | NUM_CELLS | Per-cell enable product term for combinational cells |
| cfg_reg | input | NUM_CELLS | Mode bit per cell, 1 registered, 0 combinational |
| cfg_inv | input | NUM_CELLS | Polarity bit per cell, 1 inverts the sum |
| pad_in | input | NUM_CELLS | Value observed on each pad |
| pad_out | output | NUM_CELLS | Data driven towards each pad |
| pad_oe | output | NUM_CELLS | Drive enable for each pad |
| fb_q | output | NUM_CELLS | True feedback into the array |
| fb_qn | output | NUM_CELLS | Complemented feedback into the array |

## Verification
The assertions check four things on every cycle: the flip-flop clears after reset and follows its input one edge later, registered cells use the shared enable, registered pads carry the previous cycle's adjusted sum, and feedback matches the pad data or the pad input according to the mode. Some behaviours show only in the bench's directed scenarios. These are the register feedback holding while the pad is disabled, the value that appears after a mode switch, and the isolation between cells with mixed configurations. The cycle-by-cycle reference model compares every output against these behaviours under both fixed and pseudo-random stimulus.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic {
        MODE_COMB = 1'b0,
        MODE_REG  = 1'b1
    } cell_mode_e;

    typedef struct packed {
        cell_mode_e mode;
        logic       invert;
    } cell_cfg_t;

    typedef struct packed {
        logic data;
        logic oe;
    } pad_drive_t;

    typedef struct packed {
        logic q;
        logic qn;
    } fb_pair_t;

    function automatic logic apply_polarity(input logic s, input logic inv);
        return s ^ inv;
    endfunction

endpackage

// File: rtl/olmc_flop.sv
module olmc_flop (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end

    // R1: an edge taken in reset leaves the flop cleared
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q == 1'b0));

    // R2: outside reset, the flop holds the previous cycle's input
    a_r2_q_follows_d: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q == $past(d)));

endmodule

// File: rtl/olmc_route.sv
module olmc_route
    import olmc_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       q,
    input  logic       comb_val,
    input  logic       oe_common,
    input  logic       pt_oe,
    input  logic       pad_in,
    output pad_drive_t drive,
    output fb_pair_t   fb
);

    logic fb_src;

    always_comb begin
        if (mode == MODE_REG) begin
            drive.data = q;
            drive.oe   = oe_common;
            fb_src     = q;
        end else begin
            drive.data = comb_val;
            drive.oe   = pt_oe;
            fb_src     = pad_in;
        end
        fb.q  = fb_src;
        fb.qn = ~fb_src;
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cell_cfg_t  cfg,
    input  logic       sum,
    input  logic       oe_common,
    input  logic       pt_oe,
    input  logic       pad_in,
    output pad_drive_t drive,
    output fb_pair_t   fb
);

    logic adj;
    logic q;

    assign adj = apply_polarity(sum, cfg.invert);

    olmc_flop u_flop (
        .clk (clk),
        .rst (rst),
        .d   (adj),
        .q   (q)
    );

    olmc_route u_route (
        .mode      (cfg.mode),
        .q         (q),
        .comb_val  (adj),
        .oe_common (oe_common),
        .pt_oe     (pt_oe),
        .pad_in    (pad_in),
        .drive     (drive),
        .fb        (fb)
    );

endmodule

// File: rtl/olmc_bank.sv
module olmc_bank
    import olmc_pkg::*;
#(
    parameter int NUM_CELLS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 oe_common,
    input  logic [NUM_CELLS-1:0] sum_in,
    input  logic [NUM_CELLS-1:0] pt_oe,
    input  logic [NUM_CELLS-1:0] cfg_reg,
    input  logic [NUM_CELLS-1:0] cfg_inv,
    input  logic [NUM_CELLS-1:0] pad_in,
    output logic [NUM_CELLS-1:0] pad_out,
    output logic [NUM_CELLS-1:0] pad_oe,
    output logic [NUM_CELLS-1:0] fb_q,
    output logic [NUM_CELLS-1:0] fb_qn
);

    localparam int LAST_CELL = NUM_CELLS - 1;

    for (genvar i = 0; i <= LAST_CELL; i++) begin : g_cell
        cell_cfg_t  cfg;
        pad_drive_t drive;
        fb_pair_t   fb;

        assign cfg.mode   = cfg_reg[i] ? MODE_REG : MODE_COMB;
        assign cfg.invert = cfg_inv[i];

        olmc_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg),
            .sum       (sum_in[i]),
            .oe_common (oe_common),
            .pt_oe     (pt_oe[i]),
            .pad_in    (pad_in[i]),
            .drive     (drive),
            .fb        (fb)
        );

        assign pad_out[i] = drive.data;
        assign pad_oe[i]  = drive.oe;
        assign fb_q[i]    = fb.q;
        assign fb_qn[i]   = fb.qn;

        // R4: registered cells share the common enable
        a_r4_common_oe: assert property (@(posedge clk) disable iff (rst)
            cfg_reg[i] |-> (pad_oe[i] == oe_common));

        // R2 R3: registered pad carries last cycle's adjusted sum
        a_r2_reg_pad_delay: assert property (@(posedge clk) disable iff (rst)
            (cfg_reg[i] && !$past(rst)) |->
                (pad_out[i] == ($past(sum_in[i]) ^ $past(cfg_inv[i]))));

        // R6: register feedback equals the data driven to the pad
        a_r6_reg_fb_matches: assert property (@(posedge clk) disable iff (rst)
            cfg_reg[i] |-> (fb_q[i] == pad_out[i] && fb_qn[i] != pad_out[i]));

        // R7: combinational feedback reads the pad
        a_r7_comb_fb_pad: assert property (@(posedge clk) disable iff (rst)
            !cfg_reg[i] |-> (fb_q[i] == pad_in[i] && fb_qn[i] != pad_in[i]));
    end

endmodule

// File: tb/tb_olmc_bank.sv
module tb_olmc_bank;

    localparam int N = 8;
    localparam int MAX_CYCLES = 20000;

    logic         clk = 1'b0;
    logic         rst;
    logic         oe_common;
    logic [N-1:0] sum_in, pt_oe, cfg_reg, cfg_inv, pad_in;
    logic [N-1:0] pad_out, pad_oe, fb_q, fb_qn;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit m_q [N];
    logic [31:0] rng = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    olmc_bank #(.NUM_CELLS(N)) dut (
        .clk(clk), .rst(rst), .oe_common(oe_common), .sum_in(sum_in),
        .pt_oe(pt_oe), .cfg_reg(cfg_reg), .cfg_inv(cfg_inv), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .fb_q(fb_q), .fb_qn(fb_qn)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [N-1:0] e_out, e_oe, e_fb;
        for (int i = 0; i < N; i++) begin
            bit adj = sum_in[i] ^ cfg_inv[i];
            e_out[i] = cfg_reg[i] ? m_q[i] : adj;
            e_oe[i]  = cfg_reg[i] ? oe_common : pt_oe[i];
            e_fb[i]  = cfg_reg[i] ? m_q[i] : pad_in[i];
        end
        check("R2 R3 R5 pad_out", pad_out, e_out);
        check("R4 R5 pad_oe", pad_oe, e_oe);
        check("R6 R7 fb_q", fb_q, e_fb);
        check("R6 R7 fb_qn", fb_qn, ~e_fb);
    endtask

    // inputs are set at a falling edge; one rising edge; then compare
    task automatic cycle();
        @(posedge clk);
        for (int i = 0; i < N; i++)
            m_q[i] = rst ? 1'b0 : (sum_in[i] ^ cfg_inv[i]);
        #5;
        compare_all();
        @(negedge clk);
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        rst = 1'b1; oe_common = 1'b0; sum_in = '1; pt_oe = '0;
        cfg_reg = '1; cfg_inv = '0; pad_in = '0;
        @(negedge clk);
        cycle();
        cycle();
        // R1: cleared registers after reset
        check("R1 pad_out after reset", pad_out, '0);
        check("R1 fb_qn after reset", fb_qn, '1);

        rst = 1'b0;
        // R2: registered, true polarity, patterns
        sum_in = 8'hA5; oe_common = 1'b1; cycle();
        check("R2 registered capture", pad_out, 8'hA5);
        sum_in = 8'h3C; cycle();
        check("R2 registered capture 2", pad_out, 8'h3C);

        // R3: inversion on registered path
        cfg_inv = 8'hFF; sum_in = 8'h0F; cycle();
        check("R3 inverted registered", pad_out, 8'hF0);

        // R4 R6: disable common enable; feedback keeps register value
        oe_common = 1'b0; pad_in = 8'h55; cycle();
        check("R4 disabled pads", pad_oe, '0);
        check("R6 fb while disabled", fb_q, 8'hF0);

        // R5 R7: combinational mode, pad used as input
        cfg_reg = '0; cfg_inv = 8'h0F; sum_in = 8'h33; pt_oe = 8'hC3; pad_in = 8'h99;
        cycle();
        check("R5 comb pad_out", pad_out, 8'h3C);
        check("R5 comb pad_oe", pad_oe, 8'hC3);
        check("R7 comb feedback", fb_q, 8'h99);
        // combinational response without a clock edge
        sum_in = 8'hCC; #2;
        check("R5 same-cycle response", pad_out, 8'hC3);

        // R8: flop kept loading in comb mode; switch shows last capture
        @(posedge clk); #1;
        for (int i = 0; i < N; i++) m_q[i] = sum_in[i] ^ cfg_inv[i];
        @(negedge clk);
        sum_in = 8'h00;
        cfg_reg = '1;
        #2;
        check("R8 value after mode switch", pad_out, 8'hC3);
        cycle();

        // R9: mixed configurations per cell
        cfg_reg = 8'b1010_0110; cfg_inv = 8'b0110_1100; pt_oe = 8'b0101_0101;
        oe_common = 1'b1; pad_in = 8'hE1;
        for (int k = 0; k < 6; k++) begin
            sum_in = 8'h1F << k;
            cycle();
        end
        check("R9 mixed cells oe", pad_oe, (8'b1010_0110 & 8'hFF) | (8'b0101_0101 & ~8'b1010_0110));

        // pseudo-random sweep including reset pulses
        for (int k = 0; k < 400; k++) begin
            rng = next_rng(rng); sum_in = rng[7:0]; pt_oe = rng[15:8];
            pad_in = rng[23:16]; oe_common = rng[24];
            if (rng[25] && rng[26]) cfg_reg = rng[31:24];
            if (rng[27]) cfg_inv = rng[30:23];
            rst = (rng[31:28] == 4'h0);
            cycle();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule